// File: doc/BRIEF.md
# Memory-Mapped Control Register Bank with Optional Readback

This block is an AXI4-Lite slave that holds the control inputs of a user datapath. Scalar control words take effect on their output lanes as soon as a write completes. Vector control words are staged. Each element is written into a shadow copy at its own word address. All elements then move to the datapath together when software writes a one to a separate commit address, so the datapath never sees a half-updated vector.

A compile-time switch adds a read path that returns the value last written to any control register. The switch is off by default, and while it is off every read returns zero. A second parameter sets how many registers each pipeline stage of the read selector covers. The read selector is then a chain of register stages, one stage per group of that many registers. This trades read latency for a shorter logic path.

Back-pressure follows the usual valid/ready rules. The write address channel and the write data channel are each accepted while their ready is high, and they may arrive in either order. The write response stays valid until the master takes it. While a response is pending, a new write is not carried out. Only one read is outstanding at a time: the read address ready stays low from the moment a read is accepted until its data has been taken.

Top module: `regbank_axil`

## Requirements
- R1: After reset, every scalar lane, every vector lane and the commit pulse output are zero, and a read of any register returns 0x00000000.
- R2: A completed write to byte address 4*i, for i below N_SCALAR, updates scalar lane i. The update appears on the clock edge that issues the write response. With readback enabled, a read of that address returns the stored value, for example 0x00000001 after a write of 0x1.
- R3: With READBACK = 0, a read of any address returns zero and keeps the same latency as with readback enabled.
- R4: A write to byte address 0x100 + 4*j, for j below N_VEC (N_VEC at most 4), updates only shadow element j. The vector lanes do not change. With readback enabled, a read of that address returns the shadow value.
- R5: A write to byte address 0x110 whose byte 0 is enabled and whose bit 0 is one copies every shadow element to its vector lane, and raises vec_commit_o for exactly one cycle, on the same edge. Any other write there changes nothing. A read of 0x110 returns zero.
- R6: The address and data channels are accepted independently and in either order. A write is carried out one edge after both have been accepted and no response is pending. Each write produces exactly one response, with BRESP = 00 (OKAY), which stays valid until BREADY.
- R7: Write strobe bit b enables byte b (bits 8b+7..8b) of the target register. Bytes whose strobe is clear keep their old value.
- R8: A write to an address that is none of the above changes no state and still gets an OKAY response. A read of such an address returns zero.
- R9: RVALID rises G edges after the edge that accepts the read address, where G = 0 for PORT_RATIO = 0 and G = ceil((N_SCALAR+N_VEC)/PORT_RATIO) otherwise. RRESP is 00. RVALID and RDATA hold steady until RREADY.
- R10: S_ARREADY is low while a read is outstanding, from the edge that accepts the read address until the data has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Byte enables for write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code (always OKAY) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code (always OKAY) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| scalar_o | output | 32*N_SCALAR | Scalar control lanes, lane i at bits 32i+31..32i |
| vec_o | output | 32*N_VEC | Committed vector lanes, element j at bits 32j+31..32j |
| vec_commit_o | output | 1 | One-cycle pulse when the vector lanes load |

## Verification
A write takes effect on the edge after the later of its two channel handshakes, and the write response rises on that same edge. A read's data arrives G edges after the edge that accepted the address. The bench drives inputs on falling edges and updates its queue-based model on every rising edge, using the values seen before that edge. On every falling edge it compares the scalar lanes, the vector lanes, the commit pulse and the response valid against the model. For each read, the bench counts falling edges from the address handshake to RVALID and requires exactly G. It checks this on four instances that differ in ratio and readback setting, and it also checks that RVALID and RDATA stay put for a cycle while RREADY is held low.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam int IDX_W = 8;
  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam int unsigned VEC_BASE = 32'h100;
  localparam int unsigned COMMIT_OFS = 32'h110;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } reg_sel_t;

  // Scalars take indices 0..ns-1, vector elements follow at ns..ns+nv-1
  function automatic reg_sel_t decode_addr(input logic [31:0] a,
                                           input int unsigned ns,
                                           input int unsigned nv);
    reg_sel_t s;
    int unsigned w;
    s.hit = 1'b0;
    s.idx = '0;
    w = int'(a >> 2);
    if (w < ns) begin
      s.hit = 1'b1;
      s.idx = IDX_W'(w);
    end else if (w >= VEC_BASE / 4 && w < VEC_BASE / 4 + nv) begin
      s.hit = 1'b1;
      s.idx = IDX_W'(ns + w - VEC_BASE / 4);
    end
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] old_v,
                                                    input logic [DATA_W-1:0] new_v,
                                                    input logic [STRB_W-1:0] be);
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int b = 0; b < STRB_W; b++)
      if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/regbank_wr_chan.sv
module regbank_wr_chan
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb
);
  logic aw_held, w_held;

  assign awready = !aw_held;
  assign wready  = !w_held;
  assign wr_en   = aw_held && w_held && !bvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_held <= 1'b0;
      w_held  <= 1'b0;
      bvalid  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_strb <= '0;
    end else begin
      if (wr_en) begin
        aw_held <= 1'b0;
        w_held  <= 1'b0;
        bvalid  <= 1'b1;
      end else if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
      if (awvalid && awready) begin
        aw_held <= 1'b1;
        wr_addr <= awaddr;
      end
      if (wvalid && wready) begin
        w_held  <= 1'b1;
        wr_data <= wdata;
        wr_strb <= wstrb;
      end
    end
  end
endmodule

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int N_SCALAR = 4,
  parameter int N_VEC    = 2,
  localparam int N_REGS  = N_SCALAR + N_VEC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [STRB_W-1:0]         wr_strb,
  output logic [DATA_W*N_SCALAR-1:0] scalar_o,
  output logic [DATA_W*N_VEC-1:0]    vec_o,
  output logic                      commit_o,
  output logic [DATA_W-1:0]         rb_vals [N_REGS]
);
  reg_sel_t sel;
  logic     commit_hit;

  assign sel        = decode_addr(32'(wr_addr), N_SCALAR, N_VEC);
  assign commit_hit = wr_en && (32'(wr_addr) == COMMIT_OFS) && wr_strb[0] && wr_data[0];

  for (genvar i = 0; i < N_SCALAR; i++) begin : g_scalar
    logic [DATA_W-1:0] sc_q;
    always_ff @(posedge clk) begin
      if (!rst_n) sc_q <= '0;
      else if (wr_en && sel.hit && sel.idx == IDX_W'(i))
        sc_q <= merge_bytes(sc_q, wr_data, wr_strb);
    end
    assign scalar_o[i*DATA_W +: DATA_W] = sc_q;
    assign rb_vals[i] = sc_q;
  end

  for (genvar j = 0; j < N_VEC; j++) begin : g_vec
    logic [DATA_W-1:0] sh_q, live_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_q   <= '0;
        live_q <= '0;
      end else begin
        if (wr_en && sel.hit && sel.idx == IDX_W'(N_SCALAR + j))
          sh_q <= merge_bytes(sh_q, wr_data, wr_strb);
        if (commit_hit) live_q <= sh_q;
      end
    end
    assign vec_o[j*DATA_W +: DATA_W] = live_q;
    assign rb_vals[N_SCALAR + j] = sh_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) commit_o <= 1'b0;
    else        commit_o <= commit_hit;
  end
endmodule

// File: rtl/regbank_rd_pipe.sv
module regbank_rd_pipe
  import regbank_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int N_SCALAR   = 4,
  parameter int N_VEC      = 2,
  parameter int READBACK   = 0,
  parameter int PORT_RATIO = 2,
  localparam int N_REGS    = N_SCALAR + N_VEC,
  localparam int RSAFE     = (PORT_RATIO == 0) ? 1 : PORT_RATIO,
  localparam int N_GRP     = (N_REGS + RSAFE - 1) / RSAFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  input  logic              rready,
  input  logic [DATA_W-1:0] rb_vals [N_REGS]
);
  reg_sel_t          sel;
  logic              ar_fire, busy, sel_live;
  logic              resp_v;
  logic [DATA_W-1:0] resp_d;

  assign arready  = !busy;
  assign ar_fire  = arvalid && !busy;
  assign sel      = decode_addr(32'(araddr), N_SCALAR, N_VEC);
  assign sel_live = sel.hit && (READBACK != 0);

  if (PORT_RATIO == 0) begin : g_flat
    always_comb begin
      resp_d = '0;
      for (int k = 0; k < N_REGS; k++)
        if (sel_live && sel.idx == IDX_W'(k)) resp_d = rb_vals[k];
    end
    assign resp_v = ar_fire;
  end else begin : g_chain
    logic              lk_v   [N_GRP+1];
    logic              lk_hit [N_GRP+1];
    logic [IDX_W-1:0]  lk_idx [N_GRP+1];
    logic [DATA_W-1:0] lk_d   [N_GRP+1];
    assign lk_v[0]   = ar_fire;
    assign lk_hit[0] = sel_live;
    assign lk_idx[0] = sel.idx;
    assign lk_d[0]   = '0;
    for (genvar g = 0; g < N_GRP; g++) begin : g_stage
      logic              st_v, st_hit;
      logic [IDX_W-1:0]  st_idx;
      logic [DATA_W-1:0] st_d, part;
      always_comb begin
        part = '0;
        for (int j = 0; j < RSAFE; j++) begin
          if (g*RSAFE + j < N_REGS && lk_hit[g] && lk_idx[g] == IDX_W'(g*RSAFE + j))
            part = rb_vals[(g*RSAFE + j < N_REGS) ? g*RSAFE + j : N_REGS - 1];
        end
      end
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_v   <= 1'b0;
          st_hit <= 1'b0;
          st_idx <= '0;
          st_d   <= '0;
        end else begin
          st_v   <= lk_v[g];
          st_hit <= lk_hit[g];
          st_idx <= lk_idx[g];
          st_d   <= lk_d[g] | part;
        end
      end
      assign lk_v[g+1]   = st_v;
      assign lk_hit[g+1] = st_hit;
      assign lk_idx[g+1] = st_idx;
      assign lk_d[g+1]   = st_d;
    end
    assign resp_v = lk_v[N_GRP];
    assign resp_d = lk_d[N_GRP];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      if (ar_fire) busy <= 1'b1;
      if (rvalid && rready) begin
        rvalid <= 1'b0;
        busy   <= 1'b0;
      end
      if (resp_v) begin
        rvalid <= 1'b1;
        rdata  <= resp_d;
      end
    end
  end
endmodule

// File: rtl/regbank_axil.sv
module regbank_axil
  import regbank_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int N_SCALAR   = 4,
  parameter int N_VEC      = 2,
  parameter int READBACK   = 0,
  parameter int PORT_RATIO = 2,
  localparam int N_REGS    = N_SCALAR + N_VEC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         s_awaddr,
  input  logic                      s_awvalid,
  output logic                      s_awready,
  input  logic [31:0]               s_wdata,
  input  logic [3:0]                s_wstrb,
  input  logic                      s_wvalid,
  output logic                      s_wready,
  output logic [1:0]                s_bresp,
  output logic                      s_bvalid,
  input  logic                      s_bready,
  input  logic [ADDR_W-1:0]         s_araddr,
  input  logic                      s_arvalid,
  output logic                      s_arready,
  output logic [31:0]               s_rdata,
  output logic [1:0]                s_rresp,
  output logic                      s_rvalid,
  input  logic                      s_rready,
  output logic [32*N_SCALAR-1:0]    scalar_o,
  output logic [32*N_VEC-1:0]       vec_o,
  output logic                      vec_commit_o
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [STRB_W-1:0] wr_strb;
  logic [DATA_W-1:0] rb_vals [N_REGS];

  assign s_bresp = RESP_OKAY;
  assign s_rresp = RESP_OKAY;

  regbank_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bvalid(s_bvalid), .bready(s_bready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  regbank_store #(.ADDR_W(ADDR_W), .N_SCALAR(N_SCALAR), .N_VEC(N_VEC)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .scalar_o(scalar_o), .vec_o(vec_o), .commit_o(vec_commit_o), .rb_vals(rb_vals)
  );

  regbank_rd_pipe #(.ADDR_W(ADDR_W), .N_SCALAR(N_SCALAR), .N_VEC(N_VEC),
                    .READBACK(READBACK), .PORT_RATIO(PORT_RATIO)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready), .rb_vals(rb_vals)
  );
endmodule

// File: rtl/regbank_axil_chk.sv
module regbank_axil_chk #(
  parameter int N_SCALAR = 4,
  parameter int N_VEC    = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   s_awready,
  input logic                   s_wready,
  input logic                   s_bvalid,
  input logic                   s_bready,
  input logic [1:0]             s_bresp,
  input logic                   s_arready,
  input logic                   s_rvalid,
  input logic                   s_rready,
  input logic [1:0]             s_rresp,
  input logic [31:0]            s_rdata,
  input logic [32*N_SCALAR-1:0] scalar_o,
  input logic [32*N_VEC-1:0]    vec_o,
  input logic                   vec_commit_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (scalar_o == '0 && vec_o == '0 && !vec_commit_o));

  // R6
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> s_bvalid);

  // R6
  bresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> s_bresp == 2'b00);

  // R6
  bresp_after_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_bvalid) |-> $past(!s_awready && !s_wready));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

  // R9
  rresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> s_rresp == 2'b00);

  // R10
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> !s_arready);

  // R5
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_commit_o |=> !vec_commit_o);

  // R4
  vec_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vec_o) |-> vec_commit_o);
endmodule

bind regbank_axil regbank_axil_chk #(.N_SCALAR(N_SCALAR), .N_VEC(N_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_awready(s_awready), .s_wready(s_wready),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
  .s_arready(s_arready), .s_rvalid(s_rvalid), .s_rready(s_rready),
  .s_rresp(s_rresp), .s_rdata(s_rdata),
  .scalar_o(scalar_o), .vec_o(vec_o), .vec_commit_o(vec_commit_o)
);

// File: tb/regbank_axil_test.sv
module regbank_axil_test;
  localparam int NS = 4;
  localparam int NV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [11:0] awaddr = '0, araddr = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b1, rready = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        s_awready, s_wready, s_bvalid;
  logic [1:0]  s_bresp;
  logic [32*NS-1:0] scalar_o;
  logic [32*NV-1:0] vec_o;
  logic        vec_commit_o;

  logic        ar_valid [4];
  logic        ar_ready [4];
  logic        r_valid  [4];
  logic [31:0] r_data   [4];
  logic [1:0]  r_resp   [4];

  int checks = 0, fails = 0, cyc = 0;

  regbank_axil #(.N_SCALAR(NS), .N_VEC(NV), .READBACK(1), .PORT_RATIO(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(s_awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(ar_valid[0]), .s_arready(ar_ready[0]),
    .s_rdata(r_data[0]), .s_rresp(r_resp[0]), .s_rvalid(r_valid[0]), .s_rready(rready),
    .scalar_o(scalar_o), .vec_o(vec_o), .vec_commit_o(vec_commit_o)
  );

  for (genvar k = 1; k < 4; k++) begin : g_var
    localparam int RK = (k == 1) ? 0 : ((k == 2) ? 4 : 1);
    logic [32*NS-1:0] sc_u;
    logic [32*NV-1:0] vc_u;
    logic cm_u, awr_u, wr_u, bv_u;
    logic [1:0] br_u;
    regbank_axil #(.N_SCALAR(NS), .N_VEC(NV), .READBACK((k == 3) ? 0 : 1), .PORT_RATIO(RK)) u_var (
      .clk(clk), .rst_n(rst_n),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awr_u),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wr_u),
      .s_bresp(br_u), .s_bvalid(bv_u), .s_bready(bready),
      .s_araddr(araddr), .s_arvalid(ar_valid[k]), .s_arready(ar_ready[k]),
      .s_rdata(r_data[k]), .s_rresp(r_resp[k]), .s_rvalid(r_valid[k]), .s_rready(rready),
      .scalar_o(sc_u), .vec_o(vc_u), .vec_commit_o(cm_u)
    );
  end

  function automatic int lat_of(input int k);
    int r;
    r = (k == 0) ? 2 : (k == 1) ? 0 : (k == 2) ? 4 : 1;
    return (r == 0) ? 0 : (NS + NV + r - 1) / r;
  endfunction

  // ---------------- reference model ----------------
  int unsigned aq[$];
  logic [31:0] dq[$];
  logic [3:0]  sq[$];
  bit          m_bpend = 1'b0, m_commit = 1'b0;
  logic [31:0] m_sc [NS];
  logic [31:0] m_sh [NV];
  logic [31:0] m_vec[NV];

  function automatic logic [31:0] mask_in(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
    logic [31:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] m_read(input int k, input int unsigned a);
    if (k == 3) return 32'h0;
    if (a < 4*NS) return m_sc[a/4];
    if (a >= 32'h100 && a < 32'h100 + 4*NV) return m_sh[(a - 32'h100)/4];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      aq.delete(); dq.delete(); sq.delete();
      m_bpend = 1'b0; m_commit = 1'b0;
      for (int i = 0; i < NS; i++) m_sc[i] = '0;
      for (int j = 0; j < NV; j++) begin m_sh[j] = '0; m_vec[j] = '0; end
    end else begin
      bit fire;
      fire = (aq.size() > 0) && (dq.size() > 0) && !m_bpend;
      m_commit = 1'b0;
      if (m_bpend && bready) m_bpend = 1'b0;
      if (fire) begin
        int unsigned a;
        logic [31:0] d;
        logic [3:0] s;
        a = aq.pop_front(); d = dq.pop_front(); s = sq.pop_front();
        m_bpend = 1'b1;
        if (a < 4*NS) m_sc[a/4] = mask_in(m_sc[a/4], d, s);
        else if (a >= 32'h100 && a < 32'h100 + 4*NV) m_sh[(a - 32'h100)/4] = mask_in(m_sh[(a - 32'h100)/4], d, s);
        else if (a == 32'h110 && s[0] && d[0]) begin
          for (int j = 0; j < NV; j++) m_vec[j] = m_sh[j];
          m_commit = 1'b1;
        end
      end
      if (awvalid && s_awready) aq.push_back(int'(awaddr));
      if (wvalid && s_wready) begin dq.push_back(wdata); sq.push_back(wstrb); end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NS; i++)
        chk(scalar_o[32*i +: 32] === m_sc[i], "R2 scalar lane", scalar_o[32*i +: 32], m_sc[i]);
      for (int j = 0; j < NV; j++)
        chk(vec_o[32*j +: 32] === m_vec[j], "R4 vector lane", vec_o[32*j +: 32], m_vec[j]);
      chk(vec_commit_o === m_commit, "R5 commit pulse", 32'(vec_commit_o), 32'(m_commit));
      chk(s_bvalid === m_bpend, "R6 bvalid", 32'(s_bvalid), 32'(m_bpend));
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", cyc, 50000);
      summary();
      $finish;
    end
  end

  // ---------------- bus-functional tasks ----------------
  // order: 0 both together, 1 address first, 2 data first
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s, input int order);
    bit awd, wd;
    int n;
    awaddr = a; wdata = d; wstrb = s;
    awvalid = (order != 2); wvalid = (order != 1);
    awd = 1'b0; wd = 1'b0; n = 0;
    while (!(awd && wd)) begin
      bit ah, wh;
      ah = awvalid && s_awready;
      wh = wvalid && s_wready;
      @(posedge clk); @(negedge clk);
      if (ah) begin awvalid = 1'b0; awd = 1'b1; end
      if (wh) begin wvalid = 1'b0; wd = 1'b1; end
      n++;
      if (n == 2) begin
        if (order == 1 && !wd) wvalid = 1'b1;
        if (order == 2 && !awd) awvalid = 1'b1;
      end
    end
    while (!s_bvalid) @(negedge clk);
    chk(s_bresp == 2'b00, "R6 bresp okay", 32'(s_bresp), 32'h0);
    if (bready) @(negedge clk);
  endtask

  task automatic rd(input int k, input logic [11:0] a, input string tag);
    int lat;
    logic [31:0] exp;
    araddr = a;
    ar_valid[k] = 1'b1;
    while (!ar_ready[k]) @(negedge clk);
    exp = m_read(k, int'(a));
    @(posedge clk); @(negedge clk);
    ar_valid[k] = 1'b0;
    lat = 0;
    while (!r_valid[k]) begin
      chk(!ar_ready[k], "R10 arready low while busy", 32'(ar_ready[k]), 32'h0);
      @(negedge clk);
      lat++;
    end
    chk(lat == lat_of(k), "R9 read latency", lat, lat_of(k));
    chk(r_data[k] === exp, tag, r_data[k], exp);
    chk(r_resp[k] == 2'b00, "R9 rresp okay", 32'(r_resp[k]), 32'h0);
    @(negedge clk);
    chk(r_valid[k] && r_data[k] === exp, "R9 hold without rready", r_data[k], exp);
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
    chk(!r_valid[k], "R9 rvalid drops after take", 32'(r_valid[k]), 32'h0);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) ar_valid[k] = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(scalar_o == '0 && vec_o == '0 && !vec_commit_o, "R1 outputs zero", scalar_o[31:0], 32'h0);
    chk(s_awready && s_wready && ar_ready[0] && !s_bvalid && !r_valid[0], "R1 idle handshake",
        {s_awready, s_wready, ar_ready[0], s_bvalid, r_valid[0]}, 32'h1c);
    for (int i = 0; i < NS; i++) rd(0, 12'(4*i), "R1 scalar reads zero");
    rd(0, 12'h100, "R1 vector reads zero");
    rd(0, 12'h104, "R1 vector reads zero");

    // R2 scalar write and readback, varied channel order (R6)
    wr(12'h000, 32'h1, 4'hF, 0);
    rd(0, 12'h000, "R2 readback 0x1");
    wr(12'h00C, 32'hA5A5_1234, 4'hF, 1);
    rd(0, 12'h00C, "R2 readback aw-first");
    wr(12'h008, 32'h0BAD_F00D, 4'hF, 2);
    rd(0, 12'h008, "R2 readback w-first");

    // R7 byte masking
    wr(12'h004, 32'hFFFF_FFFF, 4'b0101, 2);
    chk(scalar_o[63:32] == 32'h00FF_00FF, "R7 strobe mask", scalar_o[63:32], 32'h00FF_00FF);
    wr(12'h004, 32'h1234_5678, 4'b0010, 0);
    chk(scalar_o[63:32] == 32'h00FF_56FF, "R7 strobe mask", scalar_o[63:32], 32'h00FF_56FF);
    rd(0, 12'h004, "R7 masked readback");

    // R4 shadow writes leave vector lanes alone
    wr(12'h100, 32'h2, 4'hF, 0);
    wr(12'h104, 32'h3, 4'hF, 1);
    repeat (3) @(negedge clk);
    chk(vec_o == '0, "R4 vector held before commit", vec_o[31:0], 32'h0);
    rd(0, 12'h100, "R4 shadow readback 0x2");
    rd(0, 12'h104, "R4 shadow readback 0x3");

    // R5 commit only on bit0 = 1
    wr(12'h110, 32'hFFFF_FFFE, 4'hF, 0);
    chk(vec_o == '0, "R5 no commit on bit0 clear", vec_o[31:0], 32'h0);
    wr(12'h110, 32'h1, 4'hE, 0);
    chk(vec_o == '0, "R5 no commit with byte0 disabled", vec_o[31:0], 32'h0);
    wr(12'h110, 32'h1, 4'hF, 2);
    chk(vec_o == {32'h3, 32'h2}, "R5 vector committed", vec_o[63:32], 32'h3);
    rd(0, 12'h110, "R5 commit address reads zero");
    rd(0, 12'h100, "R5 element readback after commit");

    // R8 unmapped addresses
    wr(12'h200, 32'hDEAD_BEEF, 4'hF, 0);
    wr(12'h010, 32'hDEAD_BEEF, 4'hF, 1);
    wr(12'h108, 32'hDEAD_BEEF, 4'hF, 2);
    rd(0, 12'h200, "R8 unmapped reads zero");
    rd(0, 12'h010, "R8 unmapped reads zero");
    rd(0, 12'h108, "R8 unmapped reads zero");

    // R6 response back-pressure
    bready = 1'b0;
    wr(12'h00C, 32'h7777_0000, 4'hC, 0);
    repeat (3) begin
      @(negedge clk);
      chk(s_bvalid, "R6 bvalid held", 32'(s_bvalid), 32'h1);
    end
    bready = 1'b1;
    @(negedge clk);
    chk(!s_bvalid, "R6 bvalid released", 32'(s_bvalid), 32'h0);
    rd(0, 12'h00C, "R6 write after back-pressure");

    // R9 latency across ratios, R3 readback off
    rd(1, 12'h00C, "R9 unpipelined readback");
    rd(2, 12'h104, "R9 ratio-4 readback");
    rd(2, 12'h000, "R9 ratio-4 readback");
    rd(3, 12'h00C, "R3 readback disabled reads zero");
    rd(3, 12'h100, "R3 readback disabled reads zero");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule